// File: doc/BRIEF.md
# Push-Button Debouncer and Event Generator

This block accepts the raw, unsynchronized level of a mechanical push button and turns it into clean, clock-domain signals. It has three stages. First, two back-to-back flip-flops carry the button into the local clock domain. Second, a saturating counter accepts a press only after the synchronized level has stayed high without a break for a programmable number of cycles. Third, a one-flop edge detector watches the acceptance flag and reports it as single-cycle pulses.

The qualification length is a parameter. It should be set from the clock rate so that the window outlasts contact bounce, which can run to tens of milliseconds. The block offers three pulse outputs: one for accepted presses, one for the release that follows an accepted press, and one for either of the two. A debounced level output is also provided.

For boards whose buttons are already filtered, a build-time option removes the counter. In that mode the pulses come straight from the synchronized input.

Top module: `btn_event`

## Requirements
- R1: The raw input passes through two flip-flops before any other logic uses it. With the counter removed, a level change on the raw input appears as a pulse in the clock period after the second rising edge that samples it.
- R2: With debouncing on, a raw input that rises and stays high produces a press pulse. The pulse is exactly one clock period wide and appears in the period after the (HOLD_CYCLES+2)-th rising edge that samples the high level.
- R3: Whenever the synchronized input is low, the qualification counter returns to zero. An interrupted press therefore restarts qualification from zero, and the counter never runs past HOLD_CYCLES.
- R4: A button held high for any length of time yields exactly one press pulse.
- R5: A high excursion shorter than HOLD_CYCLES clock periods produces no pulse and leaves the debounced level at 0. This includes a one-period glitch.
- R6: Once a press has been accepted, the raw input falling produces exactly one release pulse. It is one clock period wide and appears in the period after the third rising edge that samples the low level. A rejected excursion produces no release pulse.
- R7: The change pulse is high in exactly the periods where a press or a release pulse is high. Press and release are never high together.
- R8: When the BYPASS parameter is 1, the counter is removed. Every synchronized transition, however short, is reported.
- R9: The asynchronous active-high reset drives the level and all pulses to 0. Releasing reset while the button is low creates no event.
- R10: The debounced level rises together with the press pulse, stays high while the button stays held, and falls together with the release pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| btn_raw | input | 1 | Raw button level, asynchronous, high when pressed |
| btn_level | output | 1 | Debounced button level |
| press_pulse | output | 1 | One-period pulse when a press is accepted |
| release_pulse | output | 1 | One-period pulse when an accepted press ends |
| change_pulse | output | 1 | One-period pulse on either event |

## Verification
Two things can fall in the same cycle. In the first case, the counter reaches terminal count on the same edge that the synchronized input drops. The bench provokes this by holding the button for exactly HOLD_CYCLES periods, and expects a press pulse followed immediately by a release pulse. In the second case, reset arrives in the same cycle that an accepted button is let go. The bench drives both at one clock edge and judges the result by a level of 0 and the absence of any release pulse afterwards. A scoreboard predicts every pulse and its cycle, for both a debouncing instance and a bypass instance, so any extra, missing or late pulse is reported.

// File: rtl/btn_event.sv
module btn_event #(
  parameter int unsigned HOLD_CYCLES = 2500000,
  parameter bit          BYPASS      = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_level,
  output logic press_pulse,
  output logic release_pulse,
  output logic change_pulse
);

  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

  logic          meta_q;
  logic          sync_q;
  logic [CW-1:0] cnt;
  logic          qual;
  logic          qual_d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= btn_raw;
      sync_q <= meta_q;
    end
  end

  generate
    if (BYPASS) begin : g_bypass
      assign cnt  = '0;
      assign qual = sync_q;
    end else begin : g_debounce
      assign qual = (cnt == CW'(HOLD_CYCLES));

      always_ff @(posedge clk or posedge rst) begin
        if (rst)
          cnt <= '0;
        else if (!sync_q)
          cnt <= '0;
        else if (!qual)
          cnt <= cnt + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) qual_d <= 1'b0;
    else     qual_d <= qual;
  end

  assign btn_level     = qual;
  assign press_pulse   = qual & ~qual_d;
  assign release_pulse = ~qual & qual_d;
  assign change_pulse  = qual ^ qual_d;

endmodule

module btn_event_chk #(
  parameter int unsigned HOLD_CYCLES = 8,
  parameter int unsigned CW          = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_q,
  input logic [CW-1:0] cnt,
  input logic          level,
  input logic          press,
  input logic          rel,
  input logic          change
);

  p_cnt_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(HOLD_CYCLES));

  p_idle_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !sync_q |=> (cnt == '0));

  p_press_single_r2: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  p_release_single_r6: assert property (@(posedge clk) disable iff (rst)
    rel |=> !rel);

  p_release_after_level_r6: assert property (@(posedge clk) disable iff (rst)
    rel |-> $past(level));

  p_edges_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(press && rel));

  p_change_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
    change |-> (press || rel));

  p_cause_has_change_r7: assert property (@(posedge clk) disable iff (rst)
    (press || rel) |-> change);

  p_level_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |-> press);

  p_level_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(level) |-> rel);

endmodule

bind btn_event btn_event_chk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .CW         (CW)
) u_btn_event_chk (
  .clk   (clk),
  .rst   (rst),
  .sync_q(sync_q),
  .cnt   (cnt),
  .level (btn_level),
  .press (press_pulse),
  .rel   (release_pulse),
  .change(change_pulse)
);

// File: tb/btn_event_bench.sv
module btn_event_bench;

  localparam int unsigned H = 8;

  typedef struct packed {
    logic        is_rel;
    int unsigned cyc;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;

  logic lvl_d, prs_d, rel_d, chg_d;
  logic lvl_b, prs_b, rel_b, chg_b;
  logic lvl_d_prev = 1'b0, lvl_b_prev = 1'b0;

  int unsigned cyc = 0;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  ev_t q_deb[$];
  ev_t q_byp[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  btn_event #(.HOLD_CYCLES(H), .BYPASS(1'b0)) u_btn_event (
    .clk(clk), .rst(rst), .btn_raw(btn_raw),
    .btn_level(lvl_d), .press_pulse(prs_d),
    .release_pulse(rel_d), .change_pulse(chg_d)
  );

  btn_event #(.HOLD_CYCLES(H), .BYPASS(1'b1)) u_btn_event_byp (
    .clk(clk), .rst(rst), .btn_raw(btn_raw),
    .btn_level(lvl_b), .press_pulse(prs_b),
    .release_pulse(rel_b), .change_pulse(chg_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic mon(input bit byp, input logic p, input logic r, input logic ch,
                     input logic lv, input logic lv_prev);
    ev_t e;
    string rq_p;
    rq_p = byp ? "R8/R1 press" : "R2 press";
    if (p) begin
      if (byp ? (q_byp.size() == 0) : (q_deb.size() == 0))
        chk(1'b0, {rq_p, " unexpected"}, int'(cyc), -1);
      else begin
        e = byp ? q_byp.pop_front() : q_deb.pop_front();
        chk(!e.is_rel, {rq_p, " kind"}, 0, int'(e.is_rel));
        chk(e.cyc == cyc, {rq_p, " cycle"}, int'(cyc), int'(e.cyc));
      end
    end
    if (r) begin
      if (byp ? (q_byp.size() == 0) : (q_deb.size() == 0))
        chk(1'b0, byp ? "R8 release unexpected" : "R6 release unexpected", int'(cyc), -1);
      else begin
        e = byp ? q_byp.pop_front() : q_deb.pop_front();
        chk(e.is_rel, byp ? "R8 release kind" : "R6 release kind", 1, int'(e.is_rel));
        chk(e.cyc == cyc, byp ? "R8 release cycle" : "R6 release cycle", int'(cyc), int'(e.cyc));
      end
    end
    if (p || r || ch)
      chk(ch == (p | r), "R7 change pulse", int'(ch), int'(p | r));
    if (lv != lv_prev)
      chk((p && lv) || (r && !lv), "R10 level edge with pulse", int'(lv), int'(lv_prev));
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      mon(1'b0, prs_d, rel_d, chg_d, lvl_d, lvl_d_prev);
      mon(1'b1, prs_b, rel_b, chg_b, lvl_b, lvl_b_prev);
    end
    lvl_d_prev <= lvl_d;
    lvl_b_prev <= lvl_b;
  end

  task automatic press_for(input int n, input int gap);
    int unsigned c;
    @(negedge clk);
    btn_raw = 1'b1;
    c = cyc;
    q_byp.push_back('{is_rel: 1'b0, cyc: c + 2});
    if (n >= int'(H)) q_deb.push_back('{is_rel: 1'b0, cyc: c + 2 + H});
    repeat (n) @(negedge clk);
    if (n >= int'(H) + 3) chk(lvl_d == 1'b1, "R10 level held", int'(lvl_d), 1);
    btn_raw = 1'b0;
    c = cyc;
    q_byp.push_back('{is_rel: 1'b1, cyc: c + 2});
    if (n >= int'(H)) q_deb.push_back('{is_rel: 1'b1, cyc: c + 3});
    repeat (gap) @(negedge clk);
    chk(lvl_d == 1'b0, "R5 level low after input low", int'(lvl_d), 0);
  endtask

  initial begin : main
    int unsigned c;
    repeat (3) @(negedge clk);
    chk({lvl_d, prs_d, rel_d, chg_d} == 4'b0, "R9 reset outputs", int'({lvl_d, prs_d, rel_d, chg_d}), 0);
    chk({lvl_b, prs_b, rel_b, chg_b} == 4'b0, "R9 reset outputs bypass", int'({lvl_b, prs_b, rel_b, chg_b}), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    press_for(20, 20);       // R2 R6 normal press
    press_for(1, 15);        // R5 single-cycle glitch
    press_for(H - 1, 15);    // R5 just too short
    press_for(H, 15);        // R2 R6 boundary: terminal count as input drops
    press_for(H - 1, 2);     // R3 interrupted press, first part
    press_for(H - 1, 15);    // R3 second part must restart from zero
    press_for(200, 20);      // R4 long hold, one press only

    // R9: reset in the same cycle the accepted button is let go
    @(negedge clk);
    btn_raw = 1'b1;
    c = cyc;
    q_byp.push_back('{is_rel: 1'b0, cyc: c + 2});
    q_deb.push_back('{is_rel: 1'b0, cyc: c + 2 + H});
    repeat (H + 10) @(negedge clk);
    chk(lvl_d == 1'b1, "R10 level before reset", int'(lvl_d), 1);
    btn_raw = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(lvl_d == 1'b0, "R9 level cleared by reset", int'(lvl_d), 0);
    chk(lvl_b == 1'b0, "R9 bypass level cleared by reset", int'(lvl_b), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(lvl_d == 1'b0, "R9 no event after reset", int'(lvl_d), 0);

    chk(q_deb.size() == 0, "R4 R5 R3 debounced events all seen", q_deb.size(), 0);
    chk(q_byp.size() == 0, "R8 bypass events all seen", q_byp.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule